// File: doc/BRIEF.md
# Dual-Channel Interrupt Vector Logic

This block handles interrupt bookkeeping for a pair of serial channels, A and B. Each channel keeps a receive-pending flag, a transmit-pending flag and an under-service flag for each direction. Strobes from the channel datapaths set and clear these flags. A per-channel command releases the highest source that is under service. Receive always wins over transmit: while a receive is under service, a new transmit request is held back without touching the vector. The transmit request is presented as soon as the receive is cleared or released.

The block returns three things. The first is one shared vector byte that names the most recently presented source, with the status code placed in either the low or the high bit positions. The second is one shared pending byte that gathers both channels. The third is a single interrupt request line, which is the OR of the two channels' requests. The request of each channel is gated by that channel's mode inputs: transmit interrupt enable, a two-bit receive interrupt mode, and break enable together with break status.

At most one event is acted on per clock. When strobes collide, a fixed priority chooses the event and the others are dropped. Channel A is index 0 and channel B is index 1 on every per-channel port.

Top module: `dual_irq_vector`

## Requirements
- R1: While `rstN` is low at a rising edge, all pending and under-service flags clear, `pendingO` becomes 0x00, and `vectorO` becomes the no-interrupt code for the current `statusHigh` value.
- R2: `irqO` is combinational from the flags and the mode inputs. Channel c requests when one of these holds: (`txIntEnI[c]` and transmit pending), (`rxModeI[c]` equals 2'b01 or 2'b10, and receive pending), or (`brkEnI[c]` and `brkStatI[c]`). `irqO` is the OR of the two channel requests. A receive mode of 2'b00 or 2'b11 never requests.
- R3: A receive-set strobe marks receive pending and under service on that channel. At the next edge it sets the channel's receive bit in `pendingO` and loads that channel's receive code into `vectorO`.
- R4: A transmit-set strobe always marks transmit pending. If no receive is under service on that channel, it also marks transmit under service, loads the transmit code, and sets the transmit bit in `pendingO`; the pending bit is set only when `txIntEnI[c]` is 1. If a receive is under service, `vectorO` and the transmit pending bit do not change.
- R5: Vector codes with `statusHigh`=0 are: none 0x06, receive A 0x0C, receive B 0x04, transmit A 0x08, transmit B 0x00. With `statusHigh`=1 they are: none 0x60, receive A 0x30, receive B 0x20, transmit A 0x10, transmit B 0x00. The code is picked by `statusHigh` at the edge that loads it.
- R6: `pendingO` bits are: receive A bit 5, transmit A bit 4, external A bit 3, receive B bit 2, transmit B bit 1, external B bit 0, and bits 7:6 are always 0. An external bit is `brkEnI[c]`&`brkStatI[c]` registered at each edge.
- R7: A receive-clear strobe clears receive pending and under service, clears the receive pending bit, and loads the no-interrupt code. If transmit is still pending on that channel, transmit is presented again as in R4 within the same edge.
- R8: A transmit-clear strobe clears transmit pending and under service, clears the transmit pending bit, and loads the no-interrupt code. If receive is still pending on that channel, receive is presented again as in R3 within the same edge.
- R9: A release command on a channel with receive under service clears that flag and presents a pending transmit as in R4. If only transmit is under service, it clears the transmit flag and leaves `vectorO` unchanged.
- R10: Only one event is acted on per edge. Priority from highest to lowest is receive-clear, transmit-clear, release, receive-set, transmit-set. Within one kind, channel A beats channel B. All other strobes in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| statusHigh | input | 1 | 1 places the vector status in the high bit positions |
| txIntEnI | input | 2 | Transmit interrupt enable per channel |
| rxModeI | input | 2x2 | Receive interrupt mode per channel |
| brkEnI | input | 2 | Break interrupt enable per channel |
| brkStatI | input | 2 | Break status per channel |
| rxSetI | input | 2 | Receive interrupt set strobe per channel |
| rxClrI | input | 2 | Receive interrupt clear strobe (data read) per channel |
| txSetI | input | 2 | Transmit interrupt set strobe per channel |
| txClrI | input | 2 | Transmit interrupt clear strobe per channel |
| iusRstI | input | 2 | Release highest under-service command per channel |
| vectorO | output | 8 | Modified interrupt vector |
| pendingO | output | 8 | Combined pending bits of both channels |
| irqO | output | 1 | Combined interrupt request |

## Verification
`vectorO` and `pendingO` change exactly one rising edge after a strobe, release command or break status is applied. This includes the external bits. `irqO` follows the mode and break inputs in the same cycle, and follows flag changes one edge after the strobe. The bench applies every stimulus at a falling edge and advances its reference model for the coming rising edge. It then compares all three outputs at the following falling edge. It checks `irqO` a moment after the inputs change, so mode-only changes are confirmed without waiting for an edge.

// File: rtl/dual_irq_vector_pkg.sv
package dual_irq_vector_pkg;
  localparam int NCH   = 2;
  localparam int VEC_W = 8;
  localparam int MODE_W = 2;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_CLR_RX,
    EV_CLR_TX,
    EV_IUS,
    EV_SET_RX,
    EV_SET_TX
  } evKind_e;

  // single arbitrated event handed from control to datapath
  typedef struct packed {
    evKind_e kind;
    logic    chn;
  } evStrobe_t;

  typedef enum logic [1:0] {VK_NONE, VK_RX, VK_TX} vecKind_e;

  function automatic logic [VEC_W-1:0] vecCode(vecKind_e k, logic chn, logic hi);
    case (k)
      VK_RX:   return chn ? (hi ? 8'h20 : 8'h04) : (hi ? 8'h30 : 8'h0C);
      VK_TX:   return chn ? 8'h00 : (hi ? 8'h10 : 8'h08);
      default: return hi ? 8'h60 : 8'h06;
    endcase
  endfunction

  // channel B occupies bits 2:0, channel A bits 5:3
  function automatic int baseBit(logic chn);
    return chn ? 0 : 3;
  endfunction
  function automatic int extBit(logic chn);
    return baseBit(chn);
  endfunction
  function automatic int txBit(logic chn);
    return baseBit(chn) + 1;
  endfunction
  function automatic int rxBit(logic chn);
    return baseBit(chn) + 2;
  endfunction
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import dual_irq_vector_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] rxClrI,
  input  logic [NCH-1:0] txClrI,
  input  logic [NCH-1:0] iusRstI,
  input  logic [NCH-1:0] rxSetI,
  input  logic [NCH-1:0] txSetI,
  output evStrobe_t      evO
);
  // Lowest priority is scanned first so a later, higher one overwrites it.
  always_comb begin
    evO = '{kind: EV_NONE, chn: 1'b0};
    for (int c = NCH - 1; c >= 0; c--) if (txSetI[c])  begin evO.kind = EV_SET_TX; evO.chn = 1'(c); end
    for (int c = NCH - 1; c >= 0; c--) if (rxSetI[c])  begin evO.kind = EV_SET_RX; evO.chn = 1'(c); end
    for (int c = NCH - 1; c >= 0; c--) if (iusRstI[c]) begin evO.kind = EV_IUS;    evO.chn = 1'(c); end
    for (int c = NCH - 1; c >= 0; c--) if (txClrI[c])  begin evO.kind = EV_CLR_TX; evO.chn = 1'(c); end
    for (int c = NCH - 1; c >= 0; c--) if (rxClrI[c])  begin evO.kind = EV_CLR_RX; evO.chn = 1'(c); end
  end

  AST_CLR_RX_WINS: assert property (@(posedge clk) disable iff (!rstN) (rxClrI != '0) |-> (evO.kind == EV_CLR_RX && evO.chn == !rxClrI[0]));  // R10
endmodule

// File: rtl/div_chan_req.sv
module div_chan_req
  import dual_irq_vector_pkg::*;
(
  input  logic              txIntEn,
  input  logic [MODE_W-1:0] rxMode,
  input  logic              brkEn,
  input  logic              brkStat,
  input  logic              rxPend,
  input  logic              txPend,
  output logic              reqO
);
  logic rxModeOn;
  assign rxModeOn = (rxMode == 2'b01) || (rxMode == 2'b10);
  assign reqO = (txIntEn & txPend) | (rxModeOn & rxPend) | (brkEn & brkStat);
endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import dual_irq_vector_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  evStrobe_t        evI,
  input  logic             statusHigh,
  input  logic [NCH-1:0]   txIntEn,
  input  logic [NCH-1:0]   brkEn,
  input  logic [NCH-1:0]   brkStat,
  output logic [VEC_W-1:0] vectorO,
  output logic [VEC_W-1:0] pendingO,
  output logic [NCH-1:0]   rxPendO,
  output logic [NCH-1:0]   txPendO
);
  logic [NCH-1:0]   rxPendQ, txPendQ, rxSvcQ, txSvcQ;
  logic [NCH-1:0]   rxPendD, txPendD, rxSvcD, txSvcD;
  logic [VEC_W-1:0] vecQ, vecD, pendQ, pendD;
  logic             doRx, doTx, ch;

  always_comb begin
    rxPendD = rxPendQ;
    txPendD = txPendQ;
    rxSvcD  = rxSvcQ;
    txSvcD  = txSvcQ;
    vecD    = vecQ;
    pendD   = pendQ;
    doRx    = 1'b0;
    doTx    = 1'b0;
    ch      = evI.chn;
    case (evI.kind)
      EV_SET_RX: doRx = 1'b1;
      EV_SET_TX: doTx = 1'b1;
      EV_CLR_RX: begin
        rxPendD[ch] = 1'b0;
        rxSvcD[ch]  = 1'b0;
        pendD[rxBit(ch)] = 1'b0;
        vecD = vecCode(VK_NONE, ch, statusHigh);
        doTx = txPendQ[ch];
      end
      EV_CLR_TX: begin
        txPendD[ch] = 1'b0;
        txSvcD[ch]  = 1'b0;
        pendD[txBit(ch)] = 1'b0;
        vecD = vecCode(VK_NONE, ch, statusHigh);
        doRx = rxPendQ[ch];
      end
      EV_IUS: begin
        if (rxSvcQ[ch]) begin
          rxSvcD[ch] = 1'b0;
          doTx = txPendQ[ch];
        end else if (txSvcQ[ch]) begin
          txSvcD[ch] = 1'b0;
        end
      end
      default: ;
    endcase
    if (doRx) begin
      rxPendD[ch] = 1'b1;
      rxSvcD[ch]  = 1'b1;
      pendD[rxBit(ch)] = 1'b1;
      vecD = vecCode(VK_RX, ch, statusHigh);
    end
    if (doTx) begin
      txPendD[ch] = 1'b1;
      if (!rxSvcD[ch]) begin
        txSvcD[ch] = 1'b1;
        if (txIntEn[ch]) pendD[txBit(ch)] = 1'b1;
        vecD = vecCode(VK_TX, ch, statusHigh);
      end
    end
    for (int c = 0; c < NCH; c++) pendD[extBit(1'(c))] = brkEn[c] & brkStat[c];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPendQ <= '0;
      txPendQ <= '0;
      rxSvcQ  <= '0;
      txSvcQ  <= '0;
      pendQ   <= '0;
      vecQ    <= vecCode(VK_NONE, 1'b0, statusHigh);
    end else begin
      rxPendQ <= rxPendD;
      txPendQ <= txPendD;
      rxSvcQ  <= rxSvcD;
      txSvcQ  <= txSvcD;
      pendQ   <= pendD;
      vecQ    <= vecD;
    end
  end

  assign vectorO  = vecQ;
  assign pendingO = pendQ;
  assign rxPendO  = rxPendQ;
  assign txPendO  = txPendQ;

  AST_RX_PRESENT: assert property (@(posedge clk) disable iff (!rstN) (evI.kind == EV_SET_RX) |=> (vecQ == vecCode(VK_RX, $past(evI.chn), $past(statusHigh)) && rxSvcQ[$past(evI.chn)]));  // R3
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rstN) (evI.kind == EV_SET_TX && rxSvcQ[evI.chn]) |=> $stable(vecQ));  // R4
  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rstN) (evI.kind == EV_CLR_RX && !txPendQ[evI.chn]) |=> (vecQ == vecCode(VK_NONE, 1'b0, $past(statusHigh))));  // R7
endmodule

// File: rtl/dual_irq_vector.sv
module dual_irq_vector
  import dual_irq_vector_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         statusHigh,
  input  logic [NCH-1:0]               txIntEnI,
  input  logic [NCH-1:0][MODE_W-1:0]   rxModeI,
  input  logic [NCH-1:0]               brkEnI,
  input  logic [NCH-1:0]               brkStatI,
  input  logic [NCH-1:0]               rxSetI,
  input  logic [NCH-1:0]               rxClrI,
  input  logic [NCH-1:0]               txSetI,
  input  logic [NCH-1:0]               txClrI,
  input  logic [NCH-1:0]               iusRstI,
  output logic [VEC_W-1:0]             vectorO,
  output logic [VEC_W-1:0]             pendingO,
  output logic                         irqO
);
  evStrobe_t      ev;
  logic [NCH-1:0] rxPend, txPend, chanReq;

  div_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .rxClrI(rxClrI), .txClrI(txClrI), .iusRstI(iusRstI),
    .rxSetI(rxSetI), .txSetI(txSetI),
    .evO(ev)
  );

  div_datapath u_dp (
    .clk(clk), .rstN(rstN), .evI(ev), .statusHigh(statusHigh),
    .txIntEn(txIntEnI), .brkEn(brkEnI), .brkStat(brkStatI),
    .vectorO(vectorO), .pendingO(pendingO),
    .rxPendO(rxPend), .txPendO(txPend)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_req
    div_chan_req u_req (
      .txIntEn(txIntEnI[c]), .rxMode(rxModeI[c]),
      .brkEn(brkEnI[c]), .brkStat(brkStatI[c]),
      .rxPend(rxPend[c]), .txPend(txPend[c]),
      .reqO(chanReq[c])
    );
  end

  assign irqO = |chanReq;

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rstN) ((rxPend | txPend) == '0 && (brkEnI & brkStatI) == '0) |-> !irqO);  // R2
endmodule

// File: tb/dual_irq_vector_bench.sv
module dual_irq_vector_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, statusHigh;
  logic [1:0] txIntEnI, brkEnI, brkStatI, rxSetI, rxClrI, txSetI, txClrI, iusRstI;
  logic [1:0][1:0] rxModeI;
  logic [7:0] vectorO, pendingO;
  logic irqO;

  dual_irq_vector u_dual_irq_vector (
    .clk(clk), .rstN(rstN), .statusHigh(statusHigh), .txIntEnI(txIntEnI),
    .rxModeI(rxModeI), .brkEnI(brkEnI), .brkStatI(brkStatI), .rxSetI(rxSetI),
    .rxClrI(rxClrI), .txSetI(txSetI), .txClrI(txClrI), .iusRstI(iusRstI),
    .vectorO(vectorO), .pendingO(pendingO), .irqO(irqO)
  );

  int nRun = 0, nFail = 0;
  bit mRxP[2], mTxP[2], mRxS[2], mTxS[2];
  logic [7:0] mVec, mPend;

  // R5 code table: kind 0 none, 1 receive, 2 transmit; ch 0 = A
  function automatic logic [7:0] code(int kind, int ch, bit hi);
    if (kind == 1) return (ch == 0) ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
    if (kind == 2) return (ch == 0) ? (hi ? 8'h10 : 8'h08) : 8'h00;
    return hi ? 8'h60 : 8'h06;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic presentRx(int ch);
    mRxP[ch] = 1; mRxS[ch] = 1;
    mPend[ch == 0 ? 5 : 2] = 1'b1;
    mVec = code(1, ch, statusHigh);
  endtask

  task automatic presentTx(int ch);
    mTxP[ch] = 1;
    if (!mRxS[ch]) begin
      mTxS[ch] = 1;
      if (txIntEnI[ch]) mPend[ch == 0 ? 4 : 1] = 1'b1;
      mVec = code(2, ch, statusHigh);
    end
  endtask

  function automatic bit strobe(int kind, int ch);
    case (kind)
      0: return rxClrI[ch];
      1: return txClrI[ch];
      2: return iusRstI[ch];
      3: return rxSetI[ch];
      default: return txSetI[ch];
    endcase
  endfunction

  task automatic modelStep();
    bit done;
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin mRxP[c] = 0; mTxP[c] = 0; mRxS[c] = 0; mTxS[c] = 0; end
      mPend = 8'h00;
      mVec = code(0, 0, statusHigh);
      return;
    end
    done = 0;
    for (int k = 0; k < 5; k++) begin
      for (int c = 0; c < 2; c++) begin
        if (!done && strobe(k, c)) begin
          done = 1;
          case (k)
            0: begin
              mRxP[c] = 0; mRxS[c] = 0; mPend[c == 0 ? 5 : 2] = 1'b0;
              mVec = code(0, c, statusHigh);
              if (mTxP[c]) presentTx(c);
            end
            1: begin
              mTxP[c] = 0; mTxS[c] = 0; mPend[c == 0 ? 4 : 1] = 1'b0;
              mVec = code(0, c, statusHigh);
              if (mRxP[c]) presentRx(c);
            end
            2: begin
              if (mRxS[c]) begin
                mRxS[c] = 0;
                if (mTxP[c]) presentTx(c);
              end else if (mTxS[c]) mTxS[c] = 0;
            end
            3: presentRx(c);
            default: presentTx(c);
          endcase
        end
      end
    end
    mPend[3] = brkEnI[0] & brkStatI[0];
    mPend[0] = brkEnI[1] & brkStatI[1];
  endtask

  function automatic logic expIrq();
    logic r = 1'b0;
    for (int c = 0; c < 2; c++) begin
      if (txIntEnI[c] && mTxP[c]) r = 1'b1;
      if ((rxModeI[c] == 2'b01 || rxModeI[c] == 2'b10) && mRxP[c]) r = 1'b1;
      if (brkEnI[c] && brkStatI[c]) r = 1'b1;
    end
    return r;
  endfunction

  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    check("R5 vector vs model", vectorO, mVec);
    check("R6 pending vs model", pendingO, mPend);
    check("R2 irq vs model", {7'd0, irqO}, {7'd0, expIrq()});
  endtask

  task automatic idle();
    rxSetI = 0; rxClrI = 0; txSetI = 0; txClrI = 0; iusRstI = 0;
  endtask

  task automatic expect3(string tag, logic [7:0] v, logic [7:0] p, logic i);
    check({tag, " vector"}, vectorO, v);
    check({tag, " pending"}, pendingO, p);
    check({tag, " irq"}, {7'd0, irqO}, {7'd0, i});
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    finishRun();
  end

  initial begin
    rstN = 0; statusHigh = 0; txIntEnI = 2'b11; rxModeI = 4'b0101;
    brkEnI = 0; brkStatI = 0;
    idle();
    repeat (3) tick();
    rstN = 1;
    tick();
    expect3("R1 reset", 8'h06, 8'h00, 1'b0);

    rxSetI = 2'b01; tick(); idle(); expect3("R3 rx A low", 8'h0C, 8'h20, 1'b1);
    txSetI = 2'b01; tick(); idle(); expect3("R4 tx A held", 8'h0C, 8'h20, 1'b1);
    rxClrI = 2'b01; tick(); idle(); expect3("R7 clr rx re-tx", 8'h08, 8'h10, 1'b1);
    txClrI = 2'b01; tick(); idle(); expect3("R8 clr tx", 8'h06, 8'h00, 1'b0);
    txSetI = 2'b10; tick(); idle(); expect3("R4 tx B", 8'h00, 8'h02, 1'b1);
    rxSetI = 2'b10; tick(); idle(); expect3("R3 rx B", 8'h04, 8'h06, 1'b1);
    iusRstI = 2'b10; tick(); idle(); expect3("R9 release rx", 8'h00, 8'h06, 1'b1);
    iusRstI = 2'b10; tick(); idle(); expect3("R9 release tx", 8'h00, 8'h06, 1'b1);
    rxClrI = 2'b10; tick(); idle(); expect3("R7 clr rx B", 8'h00, 8'h02, 1'b1);
    txClrI = 2'b10; tick(); idle(); expect3("R8 clr tx B", 8'h06, 8'h00, 1'b0);

    statusHigh = 1;
    rxSetI = 2'b01; tick(); idle(); expect3("R5 rx A high", 8'h30, 8'h20, 1'b1);
    rxSetI = 2'b10; tick(); idle(); expect3("R5 rx B high", 8'h20, 8'h24, 1'b1);
    rxClrI = 2'b01; tick(); idle(); expect3("R7 none high", 8'h60, 8'h04, 1'b1);
    txSetI = 2'b01; tick(); idle(); expect3("R5 tx A high", 8'h10, 8'h14, 1'b1);
    txClrI = 2'b01; tick(); idle(); expect3("R8 none high", 8'h60, 8'h04, 1'b1);
    rxClrI = 2'b10; tick(); idle(); expect3("R7 clr rx B high", 8'h60, 8'h00, 1'b0);

    rxSetI = 2'b10; txSetI = 2'b11; tick(); idle(); expect3("R10 rx set beats tx set", 8'h20, 8'h04, 1'b1);
    rxClrI = 2'b10; tick(); idle(); expect3("R10 tx set dropped", 8'h60, 8'h00, 1'b0);
    rxClrI = 2'b01; rxSetI = 2'b01; tick(); idle(); expect3("R10 clear beats set", 8'h60, 8'h00, 1'b0);

    brkEnI = 2'b01; brkStatI = 2'b01; #1;
    check("R2 break irq same cycle", {7'd0, irqO}, 8'h01);
    tick(); expect3("R6 ext A bit", 8'h60, 8'h08, 1'b1);
    brkStatI = 2'b00; tick(); expect3("R6 ext cleared", 8'h60, 8'h00, 1'b0);
    brkEnI = 2'b10; brkStatI = 2'b10; tick(); expect3("R6 ext B bit", 8'h60, 8'h01, 1'b1);
    brkEnI = 0; brkStatI = 0; tick(); idle();

    rxModeI = 4'b0111;
    rxSetI = 2'b01; tick(); idle(); expect3("R2 rx mode 11 silent", 8'h30, 8'h20, 1'b0);
    rxModeI = 4'b0110; #1;
    check("R2 rx mode 10 requests", {7'd0, irqO}, 8'h01);
    rxClrI = 2'b01; tick(); idle(); expect3("R7 clr after mode", 8'h60, 8'h00, 1'b0);

    txIntEnI = 2'b00;
    txSetI = 2'b10; tick(); idle(); expect3("R4 tx disabled no bit", 8'h00, 8'h00, 1'b0);
    txClrI = 2'b10; tick(); idle(); expect3("R8 clr tx disabled", 8'h60, 8'h00, 1'b0);
    txIntEnI = 2'b11; rxModeI = 4'b0101;

    void'($urandom(32'd2024));
    for (int n = 0; n < 3000; n++) begin
      rxSetI  = {($urandom % 6) == 0, ($urandom % 6) == 0};
      txSetI  = {($urandom % 6) == 0, ($urandom % 6) == 0};
      rxClrI  = {($urandom % 8) == 0, ($urandom % 8) == 0};
      txClrI  = {($urandom % 8) == 0, ($urandom % 8) == 0};
      iusRstI = {($urandom % 8) == 0, ($urandom % 8) == 0};
      if (($urandom % 16) == 0) begin
        statusHigh = 1'($urandom);
        txIntEnI = 2'($urandom);
        rxModeI = 4'($urandom);
        brkEnI = 2'($urandom);
        brkStatI = 2'($urandom);
      end
      tick();
    end
    idle();
    finishRun();
  end
endmodule